// File: doc/BRIEF.md
# Expander-Graph Feistel Block Cipher Engine

This engine enciphers one 128-bit block under a 128-bit key. The block is split into a left half and a right half, and the two halves pass through twenty rounds of a balanced Feistel network. The round function is a sparse, graph-local nonlinear layer. Each of the 64 bits of a half is a vertex of a fixed 3-regular graph. In one layer evaluation, every vertex recomputes its bit from its own value and the values of its three neighbours, all through one shared 4-input Boolean function. All 64 vertices update together in a single clock cycle. The same layer is applied four times inside each round so that the algebraic degree has time to build up.

A controller sequences the work with five states:

- **IDLE**: waits for a start strobe.
- **KEYMIX**: XORs the round key into a working copy of the right half.
- **GRAPH**: runs four consecutive layer evaluations, one per cycle.
- **COMBINE**: performs the Feistel update and advances the key schedule.
- **FINISH**: marks the result valid for one cycle.

The transitions are:

- IDLE→KEYMIX when start is seen.
- KEYMIX→GRAPH always.
- GRAPH→GRAPH while layer evaluations remain.
- GRAPH→COMBINE after the fourth evaluation.
- COMBINE→KEYMIX while rounds remain.
- COMBINE→FINISH after round twenty.
- FINISH→IDLE always.

A host drives plaintext and key, pulses start, waits for done, and then reads the ciphertext. The ciphertext stays on the output until the next accepted start.

Top module: `egf_core`

## Requirements
- R1: The plaintext is split so that bits [127:64] form the left half L0 and bits [63:0] form the right half R0. Each round sets L' = R and R' = L XOR F(R, rk).
- R2: Exactly 20 rounds are run. The done flag rises 120 clock cycles after the clock edge that accepts start.
- R3: The round key of round r (r = 0..19) is bits [127:64] of the input key rotated left by 13·r bits.
- R4: One graph layer maps x to y with y[i] = x[i] XOR x[(i+1) mod 64] XOR (x[(i+8) mod 64] AND x[(i+27) mod 64]) for every i in 0..63.
- R5: F(R, rk) applies the graph layer exactly 4 times in sequence to R XOR rk.
- R6: No swap follows the last round. The ciphertext is {L20, R20}, with L20 in bits [127:64].
- R7: A start strobe that arrives while a block is being processed is ignored. The running encryption finishes with its original plaintext and key.
- R8: Done is high for exactly one cycle per encryption.
- R9: After done, the ciphertext holds its value while no start is accepted, even if the plaintext and key inputs change.
- R10: Reset clears the ciphertext output to zero and holds done low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an encryption; honoured only in IDLE |
| plaintext | input | 128 | Block to encipher, sampled when start is accepted |
| key | input | 128 | Cipher key, sampled when start is accepted |
| ciphertext | output | 128 | Result {L20, R20}, valid from done onward |
| done | output | 1 | One-cycle pulse when ciphertext is valid |

## Verification
The ciphertext and done are due 120 cycles after the edge that accepts start. That figure is six cycles per round (one key mix, four graph layers, one combine) multiplied by twenty rounds. The bench counts falling edges from the accepting edge and samples at each falling edge until done appears. It requires the count to be exactly 120 and compares the ciphertext in that same cycle. It checks done again one cycle later to confirm the pulse has ended. Several cycles after that, with the inputs scrambled, it confirms that the held ciphertext has not changed.

// File: rtl/egf_pkg.sv
package egf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_KEYMIX  = 3'd1,
        ST_GRAPH   = 3'd2,
        ST_COMBINE = 3'd3,
        ST_FINISH  = 3'd4
    } egf_state_e;

endpackage

// File: rtl/egf_graph_layer.sv
module egf_graph_layer #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned HOP_A = 1,
    parameter int unsigned HOP_B = 8,
    parameter int unsigned HOP_C = 27
) (
    input  logic [WIDTH-1:0] x_in,
    output logic [WIDTH-1:0] y_out
);

    // Each vertex reads itself and three fixed neighbours (R4)
    for (genvar vi = 0; vi < WIDTH; vi++) begin : g_vertex
        localparam int unsigned NA = (vi + HOP_A) % WIDTH;
        localparam int unsigned NB = (vi + HOP_B) % WIDTH;
        localparam int unsigned NC = (vi + HOP_C) % WIDTH;
        assign y_out[vi] = x_in[vi] ^ x_in[NA] ^ (x_in[NB] & x_in[NC]);
    end

endmodule

// File: rtl/egf_key_sched.sv
module egf_key_sched #(
    parameter int unsigned KEY_W = 128,
    parameter int unsigned RK_W  = 64,
    parameter int unsigned ROT   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [KEY_W-1:0] key_in,
    output logic [RK_W-1:0]  round_key
);

    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] key_rot;

    assign key_rot   = (key_q << ROT) | (key_q >> (KEY_W - ROT));
    assign round_key = key_q[KEY_W-1 -: RK_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load) begin
            key_q <= key_in;
        end else if (advance) begin
            key_q <= key_rot;
        end
    end

    // R3
    key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> round_key == $past(key_in[KEY_W-1 -: RK_W]));

    // R3
    key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> round_key == $past(key_q[KEY_W-1-ROT -: RK_W]));

endmodule

// File: rtl/egf_ctrl.sv
module egf_ctrl
    import egf_pkg::*;
#(
    parameter int unsigned ROUNDS = 20,
    parameter int unsigned ITERS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output egf_state_e state,
    output logic       load,
    output logic       mix_en,
    output logic       graph_en,
    output logic       combine_en,
    output logic       done
);

    localparam int unsigned RND_W = $clog2(ROUNDS + 1);
    localparam int unsigned IT_W  = $clog2(ITERS + 1);

    egf_state_e       state_q, state_d;
    logic [RND_W-1:0] round_q;
    logic [IT_W-1:0]  iter_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_KEYMIX;
            ST_KEYMIX:  state_d = ST_GRAPH;
            ST_GRAPH:   if (iter_q == IT_W'(ITERS - 1)) state_d = ST_COMBINE;
            ST_COMBINE: state_d = (round_q == RND_W'(ROUNDS - 1)) ? ST_FINISH : ST_KEYMIX;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and loop counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            round_q <= '0;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE:    if (start) round_q <= '0;
                ST_KEYMIX:  iter_q <= '0;
                ST_GRAPH:   iter_q <= iter_q + 1'b1;
                ST_COMBINE: round_q <= round_q + 1'b1;
                default:    ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        load       = 1'b0;
        mix_en     = 1'b0;
        graph_en   = 1'b0;
        combine_en = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:    load       = start;
            ST_KEYMIX:  mix_en     = 1'b1;
            ST_GRAPH:   graph_en   = 1'b1;
            ST_COMBINE: combine_en = 1'b1;
            ST_FINISH:  done       = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMBINE) |-> (iter_q == IT_W'(ITERS)));

    // R2
    round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (round_q < RND_W'(ROUNDS) || state_q == ST_FINISH));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_COMBINE) |=> state_q != ST_KEYMIX);

endmodule

// File: rtl/egf_core.sv
module egf_core
    import egf_pkg::*;
#(
    parameter int unsigned BLOCK_W = 128,
    parameter int unsigned KEY_W   = 128,
    parameter int unsigned ROUNDS  = 20,
    parameter int unsigned ITERS   = 4,
    parameter int unsigned KEY_ROT = 13,
    parameter int unsigned HOP_A   = 1,
    parameter int unsigned HOP_B   = 8,
    parameter int unsigned HOP_C   = 27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLOCK_W-1:0] plaintext,
    input  logic [KEY_W-1:0]   key,
    output logic [BLOCK_W-1:0] ciphertext,
    output logic               done
);

    localparam int unsigned HALF_W = BLOCK_W / 2;

    egf_state_e        state;
    logic              load, mix_en, graph_en, combine_en;
    logic [HALF_W-1:0] half_l, half_r, work_q, layer_out, round_key;

    egf_ctrl #(
        .ROUNDS (ROUNDS),
        .ITERS  (ITERS)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .state      (state),
        .load       (load),
        .mix_en     (mix_en),
        .graph_en   (graph_en),
        .combine_en (combine_en),
        .done       (done)
    );

    egf_key_sched #(
        .KEY_W (KEY_W),
        .RK_W  (HALF_W),
        .ROT   (KEY_ROT)
    ) i_key_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (combine_en),
        .key_in    (key),
        .round_key (round_key)
    );

    egf_graph_layer #(
        .WIDTH (HALF_W),
        .HOP_A (HOP_A),
        .HOP_B (HOP_B),
        .HOP_C (HOP_C)
    ) i_layer (
        .x_in  (work_q),
        .y_out (layer_out)
    );

    // Feistel datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_l <= '0;
            half_r <= '0;
            work_q <= '0;
        end else begin
            if (load) begin
                half_l <= plaintext[BLOCK_W-1 -: HALF_W];
                half_r <= plaintext[HALF_W-1:0];
            end
            if (mix_en)   work_q <= half_r ^ round_key;
            if (graph_en) work_q <= layer_out;
            if (combine_en) begin
                half_l <= half_r;
                half_r <= half_l ^ work_q;
            end
        end
    end

    assign ciphertext = {half_l, half_r};

    // R9
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(ciphertext));

    // R1
    feistel_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        combine_en |=> half_l == $past(half_r));

    // R5
    mix_then_graph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mix_en |=> graph_en);

endmodule

// File: tb/test_egf_core.sv
module test_egf_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plaintext = '0;
    logic [127:0] key = '0;
    logic [127:0] ciphertext;
    logic         done;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    egf_core i_egf_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plaintext  (plaintext),
        .key        (key),
        .ciphertext (ciphertext),
        .done       (done)
    );

    // R4: reference graph layer
    function automatic logic [63:0] ref_layer(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++)
            y[i] = x[i] ^ x[(i + 1) % 64] ^ (x[(i + 8) % 64] & x[(i + 27) % 64]);
        return y;
    endfunction

    // R1 R3 R5 R6: reference cipher
    function automatic logic [127:0] ref_encrypt(input logic [127:0] p, input logic [127:0] k);
        logic [63:0]  l, r, w, t;
        logic [127:0] ks;
        l  = p[127:64];
        r  = p[63:0];
        ks = k;
        for (int rnd = 0; rnd < 20; rnd++) begin
            w = r ^ ks[127:64];
            for (int it = 0; it < 4; it++) w = ref_layer(w);
            t  = l;
            l  = r;
            r  = t ^ w;
            ks = {ks[114:0], ks[127:115]};
        end
        return {l, r};
    endfunction

    task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic run_vec(input logic [127:0] p, input logic [127:0] k, input bit poke);
        logic [127:0] exp;
        int           n;
        exp = ref_encrypt(p, k);
        @(negedge clk);
        plaintext = p;
        key       = k;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin
                start     = 1'b1;
                plaintext = ~p;
                key       = ~k;
            end else if (poke && n == 11) begin
                start = 1'b0;
            end
        end
        // R2: latency from accepting edge to done
        check_int("R2 latency", n, 120);
        // R1 R3 R4 R5 R6 (R7 when poked)
        check128(poke ? "R7 ciphertext after busy start" : "R1/R3/R4/R5/R6 ciphertext",
                 ciphertext, exp);
        @(negedge clk);
        // R8: done lasts one cycle
        check_int("R8 done width", int'(done), 0);
        plaintext = {$urandom, $urandom, $urandom, $urandom};
        key       = {$urandom, $urandom, $urandom, $urandom};
        repeat (5) @(negedge clk);
        // R9: held result
        check128("R9 ciphertext held", ciphertext, exp);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EED);
        // R10: reset state
        repeat (3) @(negedge clk);
        check128("R10 ciphertext in reset", ciphertext, '0);
        check_int("R10 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check128("R10 ciphertext after reset", ciphertext, '0);

        run_vec('0, '0, 1'b0);
        run_vec('1, '1, 1'b0);
        run_vec(128'h1, '0, 1'b0);
        run_vec('0, 128'h1, 1'b0);
        run_vec(128'h0123456789ABCDEF_FEDCBA9876543210,
                128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0, 1'b0);
        run_vec({$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, 1'b1);
        for (int v = 0; v < 8; v++)
            run_vec({$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, 1'b0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule